// File: doc/BRIEF.md
# SD Card SPI Command Frame Engine

This block runs one command exchange with an SD card that is in SPI mode. A controller hands it a 6-bit command index, a 32-bit argument, a CRC byte, a keep-select flag and a count of extra reply bytes. The engine lowers chip select and waits one idle byte slot. It then sends the six-byte command frame through a byte-wide exchange port and polls with 0xFF bytes until the card returns a status byte whose top bit is clear. It can gather up to four reply bytes that follow the status byte. Last, it either releases chip select and clocks one more idle byte, or it leaves chip select low so that a data phase can follow.

The bit-level shifter sits outside this block. Each transfer is requested with a one-cycle `spiStart` pulse, and the shifter answers with a one-cycle `spiDone` pulse that carries the received byte. The controller that uses the engine decides which commands to send and computes any CRC. The engine reports the status byte, the trailing word and a timeout flag, and it marks the end of the exchange with a one-cycle `done` pulse.

Top module: `sdcmd_engine`

## Requirements
- R1: The first frame byte equals 0x40 OR the command index, so bits 7:6 are 01 and bits 5:0 are the index.
- R2: Frame bytes 1 to 4 carry the argument with the most significant byte first, and frame byte 5 carries `cmdCrc` unchanged.
- R3: On acceptance `csN` goes low, and exactly one 0xFF transfer happens with `csN` low before the first frame byte.
- R4: After the frame the engine sends 0xFF bytes. The first received byte with bit 7 clear is reported on `respByte`, and `timedOut` is 0.
- R5: If POLL_LIMIT polls all return bit 7 set, the engine reports `timedOut`=1 and `respByte`=0xFF. It captures no reply bytes, ignores the keep-select flag and releases `csN`. A response that arrives on the last allowed poll is still accepted.
- R6: On release `csN` goes high before one final 0xFF transfer, and only then does `done` pulse for exactly one cycle.
- R7: With `keepSel`=1 and a valid response, `done` pulses without any release transfer, and `csN` stays low afterwards.
- R8: With `extraCnt`=N, N extra 0xFF transfers follow the status byte while `csN` is low. N is clamped to 4. The received bytes form `trailWord` big-endian and right-aligned, first byte most significant. With N=0, `trailWord` is 0.
- R9: `busy` is high from acceptance through the `done` cycle. A `cmdValid` pulse while busy is ignored and does not change the transfers or the results.
- R10: After reset `csN`=1, `busy`=0, `done`=0 and `spiStart`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request, taken when idle |
| cmdIndex | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| cmdCrc | input | 8 | Last frame byte (CRC7 and stop bit) |
| keepSel | input | 1 | Keep chip select low after a valid response |
| extraCnt | input | 3 | Number of reply bytes to capture after the status byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| respByte | output | 8 | Status byte, or 0xFF on timeout |
| trailWord | output | 32 | Captured reply bytes, big-endian, right-aligned |
| timedOut | output | 1 | No response within the poll limit |
| csN | output | 1 | Card chip select, active low |
| spiStart | output | 1 | Request one byte transfer |
| spiTx | output | 8 | Byte to transmit |
| spiDone | input | 1 | Byte transfer finished |
| spiRx | input | 8 | Byte received, valid with spiDone |

## Verification
Some properties are checked on every cycle: `done` lasts a single cycle, a transfer is never requested twice in a row, and `csN` stays low for every transfer except the release byte. The poll counter never passes its limit, and a timed-out command always ends with `csN` high. A finished command that did not time out always reports a status byte with bit 7 clear. Only the bench scenarios can show the exact byte order of the frame and the idle-byte slot before it. They also show the number of polls before a timeout, the clamping and alignment of the trailing word, the missing release byte in keep-select mode, and that a request made while busy has no effect.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int CMD_W       = 6;
  localparam int ARG_W       = 32;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 6;
  localparam int FRAME_W     = FRAME_BYTES * BYTE_W;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;
  localparam logic [1:0]        START_BITS = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_FRAME,
    ST_POLL,
    ST_TRAIL,
    ST_TAIL,
    ST_FIN
  } sdcmd_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic sendFrame;
    logic frameShift;
    logic pollInc;
    logic capResp;
    logic capTrail;
    logic markTimeout;
  } sdcmd_strobe_t;

endpackage

// File: rtl/sdcmd_dp.sv
module sdcmd_dp
  import sdcmd_pkg::*;
#(
  parameter int POLL_LIMIT = 5000,
  parameter int TRAIL_MAX  = 4,
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1),
  localparam int CNT_W     = $clog2(TRAIL_MAX + 1),
  localparam int TRAIL_W   = TRAIL_MAX * BYTE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sdcmd_strobe_t       stb,
  input  logic [CMD_W-1:0]    cmdIndex,
  input  logic [ARG_W-1:0]    cmdArg,
  input  logic [BYTE_W-1:0]   cmdCrc,
  input  logic [CNT_W-1:0]    extraCnt,
  input  logic [BYTE_W-1:0]   spiRx,
  output logic [BYTE_W-1:0]   txByte,
  output logic                rxHasResp,
  output logic                pollLast,
  output logic                trailAny,
  output logic                trailLast,
  output logic [BYTE_W-1:0]   respByte,
  output logic [TRAIL_W-1:0]  trailWord,
  output logic                timedOut
);

  logic [FRAME_W-1:0] frameSr;
  logic [POLL_W-1:0]  pollCnt;
  logic [CNT_W-1:0]   trailNeed;
  logic [CNT_W-1:0]   trailCnt;
  logic [CNT_W-1:0]   extraClamped;

  assign extraClamped = (extraCnt > CNT_W'(TRAIL_MAX)) ? CNT_W'(TRAIL_MAX) : extraCnt;

  assign txByte    = stb.sendFrame ? frameSr[FRAME_W-1 -: BYTE_W] : IDLE_BYTE;
  assign rxHasResp = ~spiRx[BYTE_W-1];
  assign pollLast  = (pollCnt == POLL_W'(POLL_LIMIT - 1));
  assign trailAny  = (trailNeed != '0);
  assign trailLast = (trailCnt == trailNeed - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameSr <= '0;
    end else if (stb.loadReq) begin
      frameSr <= {START_BITS, cmdIndex, cmdArg, cmdCrc};
    end else if (stb.frameShift) begin
      frameSr <= {frameSr[FRAME_W-BYTE_W-1:0], IDLE_BYTE};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pollCnt <= '0;
    end else if (stb.loadReq) begin
      pollCnt <= '0;
    end else if (stb.pollInc) begin
      pollCnt <= pollCnt + POLL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trailNeed <= '0;
      trailCnt  <= '0;
      trailWord <= '0;
    end else if (stb.loadReq) begin
      trailNeed <= extraClamped;
      trailCnt  <= '0;
      trailWord <= '0;
    end else if (stb.capTrail) begin
      trailCnt  <= trailCnt + CNT_W'(1);
      trailWord <= {trailWord[TRAIL_W-BYTE_W-1:0], spiRx};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respByte <= IDLE_BYTE;
      timedOut <= 1'b0;
    end else if (stb.loadReq) begin
      respByte <= IDLE_BYTE;
      timedOut <= 1'b0;
    end else if (stb.capResp) begin
      respByte <= spiRx;
    end else if (stb.markTimeout) begin
      respByte <= IDLE_BYTE;
      timedOut <= 1'b1;
    end
  end

  // R5: polling never runs past the limit
  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pollInc |-> (pollCnt < POLL_W'(POLL_LIMIT - 1)));

  // R8: no more reply bytes than requested
  a_r8_trail_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stb.capTrail |-> (trailCnt < trailNeed));

endmodule

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmdValid,
  input  logic          keepSel,
  input  logic          spiDone,
  input  logic          rxHasResp,
  input  logic          pollLast,
  input  logic          trailAny,
  input  logic          trailLast,
  output sdcmd_strobe_t stb,
  output logic          spiStart,
  output logic          csN,
  output logic          busy,
  output logic          done
);

  localparam int BC_W = $clog2(FRAME_BYTES);
  localparam logic [BC_W-1:0] LAST_BYTE = BC_W'(FRAME_BYTES - 1);

  sdcmd_state_e state, nextState;
  logic            pending;
  logic            keepReg;
  logic            csNReg, nextCs;
  logic [BC_W-1:0] byteCnt, nextByte;
  logic            xferState;
  logic            xferEnd;

  assign xferState = (state == ST_LEAD) || (state == ST_FRAME) || (state == ST_POLL) ||
                     (state == ST_TRAIL) || (state == ST_TAIL);
  assign spiStart  = xferState && !pending;
  assign xferEnd   = pending && spiDone;
  assign csN       = csNReg;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

  always_comb begin
    stb       = '0;
    nextState = state;
    nextCs    = csNReg;
    nextByte  = byteCnt;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          stb.loadReq = 1'b1;
          nextState   = ST_LEAD;
          nextCs      = 1'b0;
        end
      end
      ST_LEAD: begin
        if (xferEnd) begin
          nextState = ST_FRAME;
          nextByte  = '0;
        end
      end
      ST_FRAME: begin
        stb.sendFrame = 1'b1;
        if (xferEnd) begin
          stb.frameShift = 1'b1;
          if (byteCnt == LAST_BYTE) begin
            nextState = ST_POLL;
          end else begin
            nextByte = byteCnt + BC_W'(1);
          end
        end
      end
      ST_POLL: begin
        if (xferEnd) begin
          if (rxHasResp) begin
            stb.capResp = 1'b1;
            if (trailAny) begin
              nextState = ST_TRAIL;
            end else if (keepReg) begin
              nextState = ST_FIN;
            end else begin
              nextState = ST_TAIL;
              nextCs    = 1'b1;
            end
          end else if (pollLast) begin
            stb.markTimeout = 1'b1;
            nextState       = ST_TAIL;
            nextCs          = 1'b1;
          end else begin
            stb.pollInc = 1'b1;
          end
        end
      end
      ST_TRAIL: begin
        if (xferEnd) begin
          stb.capTrail = 1'b1;
          if (trailLast) begin
            if (keepReg) begin
              nextState = ST_FIN;
            end else begin
              nextState = ST_TAIL;
              nextCs    = 1'b1;
            end
          end
        end
      end
      ST_TAIL: begin
        if (xferEnd) nextState = ST_FIN;
      end
      ST_FIN: begin
        nextState = ST_IDLE;
      end
      default: begin
        nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
      keepReg <= 1'b0;
      csNReg  <= 1'b1;
      byteCnt <= '0;
    end else begin
      state   <= nextState;
      csNReg  <= nextCs;
      byteCnt <= nextByte;
      if (spiStart)     pending <= 1'b1;
      else if (xferEnd) pending <= 1'b0;
      if (stb.loadReq)  keepReg <= keepSel;
    end
  end

  // R6: end-of-command marker lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: one request per byte transfer
  a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    spiStart |=> !spiStart);

  // R9: a started command stays busy until its done cycle
  a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R3: card selected for every transfer except the release byte
  a_r3_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (spiStart && state != ST_TAIL) |-> !csN);

  // R6: release byte goes out with the card deselected
  a_r6_tail_release: assert property (@(posedge clk) disable iff (!rst_n)
    (spiStart && state == ST_TAIL) |-> csN);

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int POLL_LIMIT = 5000,
  parameter int TRAIL_MAX  = 4,
  localparam int CNT_W     = $clog2(TRAIL_MAX + 1),
  localparam int TRAIL_W   = TRAIL_MAX * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdValid,
  input  logic [CMD_W-1:0]   cmdIndex,
  input  logic [ARG_W-1:0]   cmdArg,
  input  logic [BYTE_W-1:0]  cmdCrc,
  input  logic               keepSel,
  input  logic [CNT_W-1:0]   extraCnt,
  output logic               busy,
  output logic               done,
  output logic [BYTE_W-1:0]  respByte,
  output logic [TRAIL_W-1:0] trailWord,
  output logic               timedOut,
  output logic               csN,
  output logic               spiStart,
  output logic [BYTE_W-1:0]  spiTx,
  input  logic               spiDone,
  input  logic [BYTE_W-1:0]  spiRx
);

  sdcmd_strobe_t stb;
  logic rxHasResp, pollLast, trailAny, trailLast;

  sdcmd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmdValid  (cmdValid),
    .keepSel   (keepSel),
    .spiDone   (spiDone),
    .rxHasResp (rxHasResp),
    .pollLast  (pollLast),
    .trailAny  (trailAny),
    .trailLast (trailLast),
    .stb       (stb),
    .spiStart  (spiStart),
    .csN       (csN),
    .busy      (busy),
    .done      (done)
  );

  sdcmd_dp #(
    .POLL_LIMIT (POLL_LIMIT),
    .TRAIL_MAX  (TRAIL_MAX)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .cmdIndex  (cmdIndex),
    .cmdArg    (cmdArg),
    .cmdCrc    (cmdCrc),
    .extraCnt  (extraCnt),
    .spiRx     (spiRx),
    .txByte    (spiTx),
    .rxHasResp (rxHasResp),
    .pollLast  (pollLast),
    .trailAny  (trailAny),
    .trailLast (trailLast),
    .respByte  (respByte),
    .trailWord (trailWord),
    .timedOut  (timedOut)
  );

  // R5: a timed-out command always ends deselected
  a_r5_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timedOut) |-> csN);

  // R4: a reported response always has its top bit clear
  a_r4_resp_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !timedOut) |-> !respByte[BYTE_W-1]);

endmodule

// File: tb/sim_sdcmd_engine.sv
`timescale 1ns/1ps
module sim_sdcmd_engine;

  localparam int LIM = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [5:0]  cmdIndex = '0;
  logic [31:0] cmdArg = '0;
  logic [7:0]  cmdCrc = '0;
  logic        keepSel = 1'b0;
  logic [2:0]  extraCnt = '0;
  logic        busy, done, timedOut, csN, spiStart;
  logic [7:0]  respByte, spiTx;
  logic [31:0] trailWord;
  logic        spiDone = 1'b0;
  logic [7:0]  spiRx = 8'hFF;

  int total = 0;
  int bad = 0;

  logic [7:0] replyQ[$];
  logic [7:0] expTx[$];
  logic       expCs[$];
  string      expTag[$];

  always #4 clk = ~clk;

  sdcmd_engine #(.POLL_LIMIT(LIM), .TRAIL_MAX(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdIndex(cmdIndex),
    .cmdArg(cmdArg), .cmdCrc(cmdCrc), .keepSel(keepSel), .extraCnt(extraCnt),
    .busy(busy), .done(done), .respByte(respByte), .trailWord(trailWord),
    .timedOut(timedOut), .csN(csN), .spiStart(spiStart), .spiTx(spiTx),
    .spiDone(spiDone), .spiRx(spiRx)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_x(input logic cs, input logic [7:0] tx, input string tag);
    expCs.push_back(cs);
    expTx.push_back(tx);
    expTag.push_back(tag);
  endtask

  // Card and shifter model: two cycles per byte, replies from replyQ
  initial begin
    int pend = 0;
    forever begin
      @(negedge clk);
      spiDone = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          spiDone = 1'b1;
          if (replyQ.size() > 0) spiRx = replyQ.pop_front();
          else spiRx = 8'hFF;
        end
      end
      if (spiStart) pend = 2;
    end
  end

  // Monitor: compares each transfer with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && spiStart) begin
        if (expTx.size() == 0) begin
          check(1'b0, "R6", "unexpected transfer", {23'd0, csN, spiTx}, 32'h0);
        end else begin
          logic [7:0] t;
          logic c;
          string g;
          t = expTx.pop_front();
          c = expCs.pop_front();
          g = expTag.pop_front();
          check(spiTx == t && csN == c, g, "transfer {cs,byte}",
                {23'd0, csN, spiTx}, {23'd0, c, t});
        end
      end
    end
  end

  task automatic runCmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] crc,
                        input bit keep, input logic [2:0] extra, input int busyPolls,
                        input logic [7:0] resp, input logic [31:0] trail, input bit interfere);
    int nTrail;
    bit tmo;
    logic [31:0] expWord;
    logic [47:0] frame;
    nTrail = (extra > 3'd4) ? 4 : int'(extra);
    tmo = (busyPolls >= LIM);
    frame = {2'b01, idx, arg, crc};
    expWord = 32'd0;
    for (int i = 0; i < 7; i++) replyQ.push_back(8'hFF);
    expect_x(1'b0, 8'hFF, "R3");
    for (int i = 0; i < 6; i++)
      expect_x(1'b0, frame[47 - 8*i -: 8], (i == 0) ? "R1" : "R2");
    if (tmo) begin
      for (int i = 0; i < LIM; i++) begin
        replyQ.push_back(8'hFF);
        expect_x(1'b0, 8'hFF, "R5");
      end
    end else begin
      for (int i = 0; i < busyPolls; i++) begin
        replyQ.push_back(8'hFF);
        expect_x(1'b0, 8'hFF, "R4");
      end
      replyQ.push_back(resp);
      expect_x(1'b0, 8'hFF, "R4");
      for (int i = nTrail - 1; i >= 0; i--) begin
        replyQ.push_back(trail[8*i +: 8]);
        expect_x(1'b0, 8'hFF, "R8");
        expWord = {expWord[23:0], trail[8*i +: 8]};
      end
    end
    if (tmo || !keep) expect_x(1'b1, 8'hFF, "R6");

    @(negedge clk);
    cmdValid = 1'b1; cmdIndex = idx; cmdArg = arg; cmdCrc = crc;
    keepSel = keep; extraCnt = extra;
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy == 1'b1 && csN == 1'b0, "R3", "busy and select after accept",
          {30'd0, busy, csN}, 32'h2);
    if (interfere) begin
      @(negedge clk);
      cmdValid = 1'b1; cmdIndex = 6'h3F; cmdArg = 32'hFFFF_FFFF; cmdCrc = 8'h00;
      keepSel = ~keep; extraCnt = 3'd1;
      @(negedge clk);
      cmdValid = 1'b0;
      check(busy == 1'b1, "R9", "busy during command", {31'd0, busy}, 32'h1);
    end
    while (!done) @(negedge clk);
    check(timedOut == tmo, tmo ? "R5" : "R4", "timedOut", {31'd0, timedOut}, {31'd0, tmo});
    check(respByte == (tmo ? 8'hFF : resp), tmo ? "R5" : "R4", "respByte",
          {24'd0, respByte}, {24'd0, tmo ? 8'hFF : resp});
    check(trailWord == expWord, "R8", "trailWord", trailWord, expWord);
    check(expTx.size() == 0, keep ? "R7" : "R6", "transfers left at done",
          expTx.size(), 32'd0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R6", "done one cycle then idle",
          {30'd0, done, busy}, 32'h0);
    repeat (4) @(negedge clk);
    check(csN == ((keep && !tmo) ? 1'b0 : 1'b1), (keep && !tmo) ? "R7" : "R6",
          "csN after command", {31'd0, csN}, {31'd0, !(keep && !tmo)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(csN == 1'b1 && busy == 1'b0 && done == 1'b0 && spiStart == 1'b0, "R10",
          "reset outputs", {28'd0, csN, busy, done, spiStart}, 32'h8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    runCmd(6'd0,  32'h0,          8'h95, 1'b0, 3'd0, 2,  8'h01, 32'h0,          1'b0); // R1 R4
    runCmd(6'd8,  32'h0000_01AA,  8'h87, 1'b0, 3'd4, 0,  8'h01, 32'h0000_01AA,  1'b0); // R8
    runCmd(6'd58, 32'h0,          8'h95, 1'b0, 3'd4, 1,  8'h00, 32'hC0FF_8000,  1'b0); // R8
    runCmd(6'd17, 32'h1234_5678,  8'h95, 1'b0, 3'd0, 3,  8'h00, 32'h0,          1'b1); // R2 R9
    runCmd(6'd9,  32'h0,          8'h95, 1'b1, 3'd0, 1,  8'h00, 32'h0,          1'b0); // R7
    runCmd(6'd55, 32'hA5A5_5A5A,  8'h95, 1'b1, 3'd2, 0,  8'h00, 32'h0000_BEEF,  1'b0); // R7 R8
    runCmd(6'd41, 32'h4000_0000,  8'h77, 1'b0, 3'd0, LIM - 1, 8'h04, 32'h0,     1'b0); // R5 boundary
    runCmd(6'd16, 32'h0000_0200,  8'h95, 1'b1, 3'd3, LIM, 8'h00, 32'h0,         1'b0); // R5 timeout
    runCmd(6'd24, 32'hDEAD_BEEF,  8'h95, 1'b0, 3'd7, 0,  8'h7F, 32'h1122_3344,  1'b0); // R8 clamp

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired R6 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule